// File: doc/BRIEF.md
# Two-Cycle Self-Correcting Sequence Counter

This block is a three-bit synchronous counter that walks one of two fixed, non-binary state cycles. A single select pin picks the cycle at run time: a four-state loop when the pin is low, a six-state loop when it is high. The pin is sampled on every active clock edge, so the cycle can change between any two steps.

Any state that is not part of the selected loop goes straight to 000 on the next enabled edge. This covers states left over after a change of select, and states the counter should never hold at all. Each state bit is kept in its own JK-type storage stage. The J and K drives are worked out from the wanted next state by the JK excitation rule.

A synchronous reset clears the counter, and a step enable freezes it. All pins are plain control and state signals, so there is no valid/ready handshake and no back-pressure to handle.

Top module: `mode_seq_counter`

## Requirements
- R1: With `long_sel` = 0 and `step_en` = 1, each rising edge moves the state 000 to 001, 001 to 010, 010 to 100, and 100 to 000.
- R2: With `long_sel` = 1 and `step_en` = 1, each rising edge moves the state 000 to 001, 001 to 011, 011 to 111, 111 to 110, 110 to 100, and 100 to 000.
- R3: With `long_sel` = 0 and `step_en` = 1, states 011, 101, 110 and 111 go to 000 on the next edge. Recovery takes one clock.
- R4: With `long_sel` = 1 and `step_en` = 1, states 010 and 101 go to 000 on the next edge. Recovery takes one clock.
- R5: States 000, 001 and 100 belong to both loops. When `long_sel` differs from its value on the previous edge while in one of these states, the next state follows the loop of the newly sampled select value.
- R6: `srst` = 1 on a rising edge sets the state to 000, whatever the values of `step_en` and `long_sel`.
- R7: With `srst` = 0 and `step_en` = 0, the state holds on every edge. Every stage then sees J = K = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high; takes priority over `step_en` |
| step_en | input | 1 | Advance enable; when low, the state holds |
| long_sel | input | 1 | Loop select: 0 picks the four-state loop, 1 picks the six-state loop |
| cnt_q | output | 3 | Current state, bit 2 is the most significant |

## Verification
The bench steers the counter into every leftover state that can be reached from the ports. It runs the long loop up to 011, 111 or 110 and then drops the select, and it stops the short loop at 010 and then raises the select. A design whose self-correction is wrong would fall into a stray loop or step to a wrong state instead of 000. The bench also flips the select exactly at 000, 001 and 100: a design with the wrong J/K terms for the shared states would keep following the old loop. Further checks cover a reset arriving with the enable high, which a design with the wrong priority would count through, and long random mixes of enable, select and reset. In these mixes a stage with bad hold behaviour would drift while the enable is low. State 101 cannot be reached from the ports, so its recovery is covered by the design's own properties.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int CNT_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic j;
    logic k;
  } jk_drive_t;
endpackage

// File: rtl/seq_next_state.sv
module seq_next_state
  import seq_pkg::*;
(
  input  logic long_sel,
  input  cnt_t cur,
  output cnt_t nxt
);
  cnt_t nxt_short;
  cnt_t nxt_long;

  always_comb begin
    case (cur)
      3'b000:  nxt_short = 3'b001;
      3'b001:  nxt_short = 3'b010;
      3'b010:  nxt_short = 3'b100;
      default: nxt_short = 3'b000;
    endcase
  end

  always_comb begin
    case (cur)
      3'b000:  nxt_long = 3'b001;
      3'b001:  nxt_long = 3'b011;
      3'b011:  nxt_long = 3'b111;
      3'b111:  nxt_long = 3'b110;
      3'b110:  nxt_long = 3'b100;
      default: nxt_long = 3'b000;
    endcase
  end

  assign nxt = long_sel ? nxt_long : nxt_short;
endmodule

// File: rtl/jk_excite.sv
module jk_excite
  import seq_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic                step_en,
  input  logic [W-1:0]        cur,
  input  logic [W-1:0]        nxt,
  output jk_drive_t [W-1:0]   drv
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    // Excitation: 0->1 needs J, 1->0 needs K, held bits need neither.
    assign drv[b].j = step_en & ~cur[b] &  nxt[b];
    assign drv[b].k = step_en &  cur[b] & ~nxt[b];
  end
endmodule

// File: rtl/jk_stage.sv
module jk_stage #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic srst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (srst) begin
      q <= RST_VAL;
    end else begin
      case ({j, k})
        2'b00:   q <= q;
        2'b01:   q <= 1'b0;
        2'b10:   q <= 1'b1;
        default: q <= ~q;
      endcase
    end
  end

  // R7
  jk_idle_hold_chk: assert property (@(posedge clk) disable iff (srst)
    (!j && !k) |=> $stable(q));

  // R6
  jk_rst_val_chk: assert property (@(posedge clk)
    srst |=> (q == RST_VAL));
endmodule

// File: rtl/mode_seq_counter.sv
module mode_seq_counter
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             srst,
  input  logic             step_en,
  input  logic             long_sel,
  output logic [CNT_W-1:0] cnt_q
);
  cnt_t                  state;
  cnt_t                  state_nxt;
  jk_drive_t [CNT_W-1:0] drv;

  seq_next_state u_next (
    .long_sel (long_sel),
    .cur      (state),
    .nxt      (state_nxt)
  );

  jk_excite #(.W(CNT_W)) u_excite (
    .step_en (step_en),
    .cur     (state),
    .nxt     (state_nxt),
    .drv     (drv)
  );

  for (genvar b = 0; b < CNT_W; b++) begin : g_stage
    jk_stage #(.RST_VAL(1'b0)) u_stage (
      .clk  (clk),
      .srst (srst),
      .j    (drv[b].j),
      .k    (drv[b].k),
      .q    (state[b])
    );
  end

  assign cnt_q = state;

  // R1
  short_step_a_chk: assert property (@(posedge clk) disable iff (srst)
    (step_en && !long_sel && cnt_q == 3'b001) |=> (cnt_q == 3'b010));

  // R1
  short_step_b_chk: assert property (@(posedge clk) disable iff (srst)
    (step_en && !long_sel && cnt_q == 3'b010) |=> (cnt_q == 3'b100));

  // R2
  long_step_a_chk: assert property (@(posedge clk) disable iff (srst)
    (step_en && long_sel && cnt_q == 3'b011) |=> (cnt_q == 3'b111));

  // R2
  long_step_b_chk: assert property (@(posedge clk) disable iff (srst)
    (step_en && long_sel && cnt_q == 3'b111) |=> (cnt_q == 3'b110));

  // R3
  short_recover_chk: assert property (@(posedge clk) disable iff (srst)
    (step_en && !long_sel &&
     (cnt_q == 3'b011 || cnt_q == 3'b101 || cnt_q == 3'b110 || cnt_q == 3'b111))
    |=> (cnt_q == 3'b000));

  // R4
  long_recover_chk: assert property (@(posedge clk) disable iff (srst)
    (step_en && long_sel && (cnt_q == 3'b010 || cnt_q == 3'b101))
    |=> (cnt_q == 3'b000));

  // R5
  shared_mode_chk: assert property (@(posedge clk) disable iff (srst)
    (step_en && cnt_q == 3'b001) |=> (cnt_q == ($past(long_sel) ? 3'b011 : 3'b010)));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    srst |=> (cnt_q == 3'b000));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (srst)
    !step_en |=> $stable(cnt_q));
endmodule

// File: tb/mode_seq_counter_tb.sv
module mode_seq_counter_tb;
  logic       clk = 1'b0;
  logic       srst = 1'b1;
  logic       step_en = 1'b0;
  logic       long_sel = 1'b0;
  logic [2:0] cnt_q;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  int  ref_st = 0;
  bit  prev_sel = 1'b0;

  always #5 clk = ~clk;

  mode_seq_counter u_dut (
    .clk      (clk),
    .srst     (srst),
    .step_en  (step_en),
    .long_sel (long_sel),
    .cnt_q    (cnt_q)
  );

  function automatic int ref_next(int st, bit sel);
    int lp [6];
    int len;
    if (sel) begin
      lp = '{0, 1, 3, 7, 6, 4};
      len = 6;
    end else begin
      lp = '{0, 1, 2, 4, 0, 0};
      len = 4;
    end
    for (int i = 0; i < len; i++)
      if (lp[i] == st) return lp[(i + 1) % len];
    return 0;
  endfunction

  function automatic bit in_loop(int st, bit sel);
    return ref_next(st, sel) != 0 || st == 4;
  endfunction

  function automatic string tag_of(int st, bit r, bit e, bit sel, bit psel);
    if (r) return "R6";
    if (!e) return "R7";
    if (!in_loop(st, sel)) return sel ? "R4" : "R3";
    if (sel != psel && (st == 0 || st == 1 || st == 4)) return "R5";
    return sel ? "R2" : "R1";
  endfunction

  task automatic check(int got, int exp, string tag);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: cnt_q=%03b expected %03b at %0t", tag, got[2:0], exp[2:0], $time);
    end
  endtask

  // Drive one cycle at the falling edge, compare at the next falling edge.
  task automatic cyc(bit r, bit e, bit sel);
    string tag;
    int    exp;
    srst = r;
    step_en = e;
    long_sel = sel;
    tag = tag_of(ref_st, r, e, sel, prev_sel);
    exp = r ? 0 : (e ? ref_next(ref_st, sel) : ref_st);
    @(negedge clk);
    check(int'(cnt_q), exp, tag);
    ref_st = exp;
    prev_sel = sel;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(int'(cnt_q), 0, "R6");
    ref_st = 0;

    // R1: short loop twice round
    for (int i = 0; i < 8; i++) cyc(0, 1, 0);
    // R2: long loop twice round
    for (int i = 0; i < 12; i++) cyc(0, 1, 1);
    // R3: leave long loop at 011, 111, 110 by dropping the select
    cyc(0, 1, 1); cyc(0, 1, 1);                   // 000->001->011
    cyc(0, 1, 0);                                 // 011->000
    cyc(0, 1, 1); cyc(0, 1, 1); cyc(0, 1, 1);     // ->111
    cyc(0, 1, 0);                                 // 111->000
    for (int i = 0; i < 4; i++) cyc(0, 1, 1);     // ->110
    cyc(0, 1, 0);                                 // 110->000
    // R4: leave short loop at 010 by raising the select
    cyc(0, 1, 0); cyc(0, 1, 0);                   // ->010
    cyc(0, 1, 1);                                 // 010->000
    // R5: flip select on shared states
    cyc(0, 1, 0);                                 // R5 at 000 -> 001
    cyc(0, 1, 1);                                 // R5 at 001 -> 011
    cyc(0, 1, 1); cyc(0, 1, 1); cyc(0, 1, 1);     // ->100
    cyc(0, 1, 0);                                 // R5 at 100 -> 000
    // R7: hold with enable low under both selects
    cyc(0, 1, 0);
    cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 1);
    // R6: reset with enable high mid-count
    cyc(0, 1, 1);
    cyc(1, 1, 1);
    cyc(1, 1, 0);
    cyc(0, 1, 1);

    // Random mix of select, enable and reset
    for (int i = 0; i < 4000; i++) begin
      bit r, e, s;
      r = ($urandom_range(0, 39) == 0);
      e = ($urandom_range(0, 4) != 0);
      s = (i % 50 < 25) ? ($urandom_range(0, 7) == 0) : ($urandom_range(0, 7) != 0);
      cyc(r, e, s);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, got none expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule